// File: doc/BRIEF.md
# Limit-Check Interrupt Status Unit

This block watches a set of monitored readings: seven unsigned 8-bit voltage samples, one two's-complement temperature byte and three unsigned fan tachometer counts. It checks them against programmable limits each time an update strobe marks a fresh set of samples. Every violation sets a sticky bit in one of two 8-bit status registers. A status register keeps its bits until software reads it, and the read clears them. Three external event inputs also set status bits: a board-temperature event, a boot-storage overflow and a system-management event. A chassis-intrusion latch sets its own bit as well.

Two 16-bit enable masks, one per interrupt path, select which status bits may raise the system-management output and which may raise the shared NMI/IRQ output. Configuration bits enable each path, force both quiet, and route the NMI/IRQ path to either the NMI pin or the IRQ pin. The readings, limits, configuration and masks arrive as inputs from the surrounding register file and sampling logic. The status registers and the three interrupt pins are the outputs.

Top module: `limit_irq_unit`

## Requirements
- R1: On a cycle with `upd_i` high, voltage channel k sets its status bit when its sample is strictly above its high limit or strictly below its low limit (unsigned). Channels 0 to 3 use status-1 bits 0 to 3. Channels 4 to 6 use status-2 bits 0 to 2. A sample equal to a limit sets nothing.
- R2: A voltage high limit of 0xFF disables the high-side check of that channel. The low-side check of that channel still applies.
- R3: While the temperature hysteresis value is not 127, the unit keeps a "hot" state that is clear after reset. An update whose reading is above the high limit while not hot sets status-1 bit 4 and enters hot. An update whose reading is below the hysteresis value while hot sets bit 4 and leaves hot. Any other update sets nothing.
- R4: While the hysteresis value is 127 (0x7F), every update whose reading is above the high limit sets status-1 bit 4.
- R5: Temperature, high limit and hysteresis value compare as 8-bit two's-complement numbers.
- R6: On an update, fan k sets its bit when its count is strictly above its limit, unless that limit is 0xFF. Fans 0 and 1 use status-1 bits 6 and 7. Fan 2 uses status-2 bit 3.
- R7: Whenever `bti_ev_i` is high, status-1 bit 5 is set. `ovf_ev_i` sets status-2 bit 5 and `smi_ev_i` sets status-2 bit 6. Status-2 bit 7 stays 0.
- R8: A cycle with `rd1_i` (or `rd2_i`) high clears status register 1 (or 2) at the next edge. A bit being set in that same cycle survives the clear.
- R9: Without a read, status bits only accumulate. Limit comparisons have no effect on cycles without `upd_i`.
- R10: `smi_o` = cfg bit 1 and any(status AND `smi_mask_i`). The NMI/IRQ path = cfg bit 2 and any(status AND `nmi_mask_i`), driving `nmi_o` when cfg bit 5 is 1 and `irq_o` when it is 0. Mask bits [7:0] apply to status 1 and bits [15:8] to status 2, with 1 meaning enabled.
- R11: While cfg bit 3 is 1, `smi_o`, `irq_o` and `nmi_o` are all low.
- R12: `chas_ev_i` sets the intrusion latch. A `nmi2_wr_i` cycle with `nmi2_wd_i` bit 7 set clears it, but an event in that same cycle wins. While the latch holds, status-2 bit 4 is set again every cycle, one cycle after the latch is set.
- R13: A synchronous active-low reset clears both status registers, the intrusion latch and the temperature hot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | A fresh set of samples is present; run the limit checks |
| volt_i | input | 56 | Voltage samples, channel k at [8k+7:8k] |
| volt_hi_i | input | 56 | Voltage high limits, same packing |
| volt_lo_i | input | 56 | Voltage low limits, same packing |
| temp_i | input | 8 | Temperature, two's complement |
| temp_hi_i | input | 8 | Temperature high limit |
| temp_hyst_i | input | 8 | Temperature hysteresis value (127 selects comparator mode) |
| fan_i | input | 24 | Fan counts, fan k at [8k+7:8k] |
| fan_lim_i | input | 24 | Fan count limits |
| bti_ev_i | input | 1 | Board-temperature event |
| ovf_ev_i | input | 1 | Boot-storage overflow event |
| smi_ev_i | input | 1 | System-management event |
| chas_ev_i | input | 1 | Chassis-intrusion event |
| cfg_i | input | 8 | Config: bit1 SMI enable, bit2 NMI/IRQ enable, bit3 force quiet, bit5 NMI select |
| smi_mask_i | input | 16 | SMI enable mask |
| nmi_mask_i | input | 16 | NMI/IRQ enable mask |
| nmi2_wr_i | input | 1 | Write strobe to the second NMI/IRQ mask byte |
| nmi2_wd_i | input | 8 | Write data for that byte; bit 7 clears the intrusion latch |
| rd1_i | input | 1 | Read of status register 1 |
| rd2_i | input | 1 | Read of status register 2 |
| stat1_o | output | 8 | Status register 1 |
| stat2_o | output | 8 | Status register 2 |
| smi_o | output | 1 | System-management interrupt |
| irq_o | output | 1 | IRQ interrupt |
| nmi_o | output | 1 | NMI interrupt |

## Verification
A wrong bit in either status register appears on `stat1_o` or `stat2_o` at the sampling point after the edge that produced it. It appears on an interrupt pin in the same cycle once any mask selects that bit. A wrong temperature hot state stays hidden until the next update that crosses a threshold. The bench therefore drives rising, falling and re-crossing temperature sequences, so that a flipped state shows up as a missing or extra bit 4 within one update. A stuck intrusion latch shows up one cycle after a clear write, because status-2 bit 4 returns after a read.

// File: rtl/limit_irq_pkg.sv
// Package: shared constants for the limit-check interrupt status unit.
// Assumes seven voltage channels and three fans; status bit positions are
// fixed because software decodes them.
package limit_irq_pkg;
    localparam int NUM_VOLT  = 7;
    localparam int NUM_FAN   = 3;
    localparam int SREG_W    = 8;
    localparam int NUM_SREG  = 2;
    localparam int S1_VOLT_N = 4;                    // voltage channels in status 1
    localparam int S2_VOLT_N = NUM_VOLT - S1_VOLT_N;  // voltage channels in status 2

    // status 1 positions
    localparam int S1_TEMP = 4;
    localparam int S1_BTI  = 5;
    localparam int S1_FAN0 = 6;
    localparam int S1_FAN1 = 7;
    // status 2 positions
    localparam int S2_FAN2 = 3;
    localparam int S2_CHAS = 4;
    localparam int S2_OVF  = 5;
    localparam int S2_SMI  = 6;

    // config bits
    localparam int CFG_SMI_EN  = 1;
    localparam int CFG_NMI_EN  = 2;
    localparam int CFG_QUIET   = 3;
    localparam int CFG_NMI_SEL = 5;
    // write data bit that clears the intrusion latch
    localparam int CHAS_CLR_BIT = 7;

    typedef enum logic {
        TMODE_HYST = 1'b0,
        TMODE_CMP  = 1'b1
    } tmode_e;
endpackage

// File: rtl/limit_window.sv
// Module: limit_window
// Unsigned window check of one reading. The high side is skipped when the
// limit is all ones; the low side exists only when USE_LOW is set.
// Assumes: purely combinational, caller qualifies the result with its strobe.
module limit_window #(
    parameter int DW      = 8,
    parameter bit USE_LOW = 1'b1
) (
    input  logic [DW-1:0] val_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    output logic          out_o
);
    localparam logic [DW-1:0] OFF_CODE = '1;

    logic over;
    logic under;

    // high-side compare, disabled by the all-ones code
    assign over = (hi_i != OFF_CODE) && (val_i > hi_i);

    generate
        if (USE_LOW) begin : g_low
            // low-side compare
            assign under = (val_i < lo_i);
        end else begin : g_nolow
            logic unused_lo;
            assign unused_lo = ^lo_i;
            assign under     = 1'b0;
        end
    endgenerate

    assign out_o = over | under;
endmodule

// File: rtl/temp_watch.sv
// Module: temp_watch
// Signed temperature event generator. Comparator mode when the hysteresis
// value equals the largest positive code; otherwise hysteresis mode with a
// hot state. Assumes evt_o is only meaningful as a one-cycle set request.
module temp_watch
    import limit_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [DW-1:0] t_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] hyst_i,
    output logic          evt_o
);
    localparam logic [DW-1:0] CMP_CODE = {1'b0, {(DW-1){1'b1}}};

    tmode_e mode;
    logic   above;
    logic   below;
    logic   hot_q;
    logic   hot_d;

    // mode select and signed compares
    assign mode  = (hyst_i == CMP_CODE) ? TMODE_CMP : TMODE_HYST;
    assign above = $signed(t_i) > $signed(hi_i);
    assign below = $signed(t_i) < $signed(hyst_i);

    // event and next hot state
    always_comb begin
        evt_o = 1'b0;
        hot_d = hot_q;
        if (upd_i) begin
            case (mode)
                TMODE_CMP: begin
                    evt_o = above;
                    hot_d = above;
                end
                default: begin
                    if (!hot_q && above) begin
                        evt_o = 1'b1;
                        hot_d = 1'b1;
                    end else if (hot_q && below) begin
                        evt_o = 1'b1;
                        hot_d = 1'b0;
                    end
                end
            endcase
        end
    end

    // hot state register
    always_ff @(posedge clk) begin
        if (!rst_n) hot_q <= 1'b0;
        else        hot_q <= hot_d;
    end
endmodule

// File: rtl/stat_reg.sv
// Module: stat_reg
// Sticky status register, cleared by a read. Set requests in the read cycle
// are kept so no event is lost. Assumes rd_i is a single-cycle strobe.
module stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    output logic [W-1:0] q_o
);
    // accumulate, or restart from the new sets on a read
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (rd_i) q_o <= set_i;
        else           q_o <= q_o | set_i;
    end
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Masks the status onto the SMI path and the NMI/IRQ path, applies the
// enables, the quiet override and the NMI/IRQ route. Combinational.
module irq_gate #(
    parameter int SW = 16
) (
    input  logic [SW-1:0] stat_i,
    input  logic [SW-1:0] smask_i,
    input  logic [SW-1:0] nmask_i,
    input  logic          smi_en_i,
    input  logic          nmi_en_i,
    input  logic          quiet_i,
    input  logic          nmi_sel_i,
    output logic          smi_o,
    output logic          irq_o,
    output logic          nmi_o
);
    localparam int NPATH = 2;

    logic [SW-1:0]    mask [NPATH];
    logic [NPATH-1:0] en;
    logic [NPATH-1:0] hit;

    assign mask[0] = smask_i;
    assign mask[1] = nmask_i;
    assign en      = {nmi_en_i, smi_en_i};

    // per path: any enabled status bit, gated by its enable and the override
    generate
        for (genvar p = 0; p < NPATH; p++) begin : g_path
            assign hit[p] = (|(stat_i & mask[p])) & en[p] & ~quiet_i;
        end
    endgenerate

    // route the second path
    assign smi_o = hit[0];
    assign nmi_o = hit[1] & nmi_sel_i;
    assign irq_o = hit[1] & ~nmi_sel_i;
endmodule

// File: rtl/limit_irq_unit.sv
// Module: limit_irq_unit (top)
// Runs voltage, temperature and fan limit checks on each update strobe,
// collects violations and external events in two clear-on-read status
// registers, keeps a chassis-intrusion latch and drives SMI, IRQ and NMI.
// Assumes limits, config and masks are held stable by a register file.
module limit_irq_unit
    import limit_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [NUM_VOLT*DW-1:0] volt_i,
    input  logic [NUM_VOLT*DW-1:0] volt_hi_i,
    input  logic [NUM_VOLT*DW-1:0] volt_lo_i,
    input  logic [DW-1:0]          temp_i,
    input  logic [DW-1:0]          temp_hi_i,
    input  logic [DW-1:0]          temp_hyst_i,
    input  logic [NUM_FAN*DW-1:0]  fan_i,
    input  logic [NUM_FAN*DW-1:0]  fan_lim_i,
    input  logic                   bti_ev_i,
    input  logic                   ovf_ev_i,
    input  logic                   smi_ev_i,
    input  logic                   chas_ev_i,
    input  logic [7:0]             cfg_i,
    input  logic [2*SREG_W-1:0]    smi_mask_i,
    input  logic [2*SREG_W-1:0]    nmi_mask_i,
    input  logic                   nmi2_wr_i,
    input  logic [7:0]             nmi2_wd_i,
    input  logic                   rd1_i,
    input  logic                   rd2_i,
    output logic [SREG_W-1:0]      stat1_o,
    output logic [SREG_W-1:0]      stat2_o,
    output logic                   smi_o,
    output logic                   irq_o,
    output logic                   nmi_o
);
    logic [NUM_VOLT-1:0] volt_viol;
    logic [NUM_FAN-1:0]  fan_viol;
    logic                temp_evt;
    logic                chas_q;
    logic [SREG_W-1:0]   set_v  [NUM_SREG];
    logic [SREG_W-1:0]   stat_q [NUM_SREG];
    logic [NUM_SREG-1:0] rd_v;
    logic                unused_in;

    assign unused_in = ^{cfg_i[7:6], cfg_i[4], cfg_i[0], nmi2_wd_i[6:0]};

    // voltage window checks
    generate
        for (genvar v = 0; v < NUM_VOLT; v++) begin : g_volt
            limit_window #(.DW(DW), .USE_LOW(1'b1)) u_win (
                .val_i (volt_i[v*DW +: DW]),
                .hi_i  (volt_hi_i[v*DW +: DW]),
                .lo_i  (volt_lo_i[v*DW +: DW]),
                .out_o (volt_viol[v])
            );
        end
        for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
            limit_window #(.DW(DW), .USE_LOW(1'b0)) u_win (
                .val_i (fan_i[f*DW +: DW]),
                .hi_i  (fan_lim_i[f*DW +: DW]),
                .lo_i  ({DW{1'b0}}),
                .out_o (fan_viol[f])
            );
        end
    endgenerate

    // temperature event generator
    temp_watch #(.DW(DW)) u_temp (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (upd_i),
        .t_i    (temp_i),
        .hi_i   (temp_hi_i),
        .hyst_i (temp_hyst_i),
        .evt_o  (temp_evt)
    );

    // chassis-intrusion latch: event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) chas_q <= 1'b0;
        else        chas_q <= chas_ev_i |
                              (chas_q & ~(nmi2_wr_i & nmi2_wd_i[CHAS_CLR_BIT]));
    end

    // map violations and events onto status bit positions
    always_comb begin
        set_v[0] = '0;
        set_v[1] = '0;
        if (upd_i) begin
            set_v[0][S1_VOLT_N-1:0] = volt_viol[S1_VOLT_N-1:0];
            set_v[1][S2_VOLT_N-1:0] = volt_viol[NUM_VOLT-1:S1_VOLT_N];
            set_v[0][S1_FAN0]       = fan_viol[0];
            set_v[0][S1_FAN1]       = fan_viol[1];
            set_v[1][S2_FAN2]       = fan_viol[2];
        end
        set_v[0][S1_TEMP] = temp_evt;
        set_v[0][S1_BTI]  = bti_ev_i;
        set_v[1][S2_OVF]  = ovf_ev_i;
        set_v[1][S2_SMI]  = smi_ev_i;
        set_v[1][S2_CHAS] = chas_q;
    end

    assign rd_v = {rd2_i, rd1_i};

    // the two status registers
    generate
        for (genvar r = 0; r < NUM_SREG; r++) begin : g_sreg
            stat_reg #(.W(SREG_W)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[r]),
                .rd_i  (rd_v[r]),
                .q_o   (stat_q[r])
            );
        end
    endgenerate

    assign stat1_o = stat_q[0];
    assign stat2_o = stat_q[1];

    // interrupt outputs
    irq_gate #(.SW(2*SREG_W)) u_gate (
        .stat_i    ({stat_q[1], stat_q[0]}),
        .smask_i   (smi_mask_i),
        .nmask_i   (nmi_mask_i),
        .smi_en_i  (cfg_i[CFG_SMI_EN]),
        .nmi_en_i  (cfg_i[CFG_NMI_EN]),
        .quiet_i   (cfg_i[CFG_QUIET]),
        .nmi_sel_i (cfg_i[CFG_NMI_SEL]),
        .smi_o     (smi_o),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o)
    );
endmodule

// File: rtl/limit_irq_chk.sv
// Module: limit_irq_chk
// Property checker for limit_irq_unit, attached with bind below.
module limit_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_i,
    input logic       rd1_i,
    input logic       bti_ev_i,
    input logic [7:0] cfg_i,
    input logic [7:0] stat1_o,
    input logic       smi_o,
    input logic       irq_o,
    input logic       nmi_o,
    input logic       nmi2_wr_i,
    input logic       nmi2_clr_bit,
    input logic       chas_ev_i,
    input logic       chas_q
);
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_i && !upd_i && !bti_ev_i) |=> (stat1_o == 8'h00)); // R8

    AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !rd1_i && !bti_ev_i) |=> (stat1_o == $past(stat1_o))); // R9

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd1_i) |=> ((stat1_o & $past(stat1_o)) == $past(stat1_o))); // R9

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[3] |-> (!smi_o && !irq_o && !nmi_o)); // R11

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && nmi_o)); // R10

    AST_CHAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        chas_ev_i |=> chas_q); // R12

    AST_CHAS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi2_wr_i && nmi2_clr_bit && !chas_ev_i) |=> !chas_q); // R12
endmodule

bind limit_irq_unit limit_irq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_i        (upd_i),
    .rd1_i        (rd1_i),
    .bti_ev_i     (bti_ev_i),
    .cfg_i        (cfg_i),
    .stat1_o      (stat1_o),
    .smi_o        (smi_o),
    .irq_o        (irq_o),
    .nmi_o        (nmi_o),
    .nmi2_wr_i    (nmi2_wr_i),
    .nmi2_clr_bit (nmi2_wd_i[7]),
    .chas_ev_i    (chas_ev_i),
    .chas_q       (chas_q)
);

// File: tb/limit_irq_unit_tb_top.sv
// Bench: behavioural reference model compared with the outputs every clock.
module limit_irq_unit_tb_top;
    localparam int DW = 8;
    localparam int NV = 7;
    localparam int NF = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n, upd_i, bti_ev_i, ovf_ev_i, smi_ev_i, chas_ev_i;
    logic            nmi2_wr_i, rd1_i, rd2_i;
    logic [NV*DW-1:0] volt_i, volt_hi_i, volt_lo_i;
    logic [NF*DW-1:0] fan_i, fan_lim_i;
    logic [7:0]      temp_i, temp_hi_i, temp_hyst_i, cfg_i, nmi2_wd_i;
    logic [15:0]     smi_mask_i, nmi_mask_i;
    logic [7:0]      stat1_o, stat2_o;
    logic            smi_o, irq_o, nmi_o;

    int volt[NV], vhi[NV], vlo[NV], fan[NF], flim[NF];
    int m_s1, m_s2, m_hot, m_chas;
    int nvec, nbad;
    bit done;
    string cur_req;

    always_comb begin
        for (int i = 0; i < NV; i++) begin
            volt_i[i*DW +: DW]    = volt[i][7:0];
            volt_hi_i[i*DW +: DW] = vhi[i][7:0];
            volt_lo_i[i*DW +: DW] = vlo[i][7:0];
        end
        for (int i = 0; i < NF; i++) begin
            fan_i[i*DW +: DW]     = fan[i][7:0];
            fan_lim_i[i*DW +: DW] = flim[i][7:0];
        end
    end

    limit_irq_unit #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
        .volt_i(volt_i), .volt_hi_i(volt_hi_i), .volt_lo_i(volt_lo_i),
        .temp_i(temp_i), .temp_hi_i(temp_hi_i), .temp_hyst_i(temp_hyst_i),
        .fan_i(fan_i), .fan_lim_i(fan_lim_i),
        .bti_ev_i(bti_ev_i), .ovf_ev_i(ovf_ev_i), .smi_ev_i(smi_ev_i),
        .chas_ev_i(chas_ev_i), .cfg_i(cfg_i),
        .smi_mask_i(smi_mask_i), .nmi_mask_i(nmi_mask_i),
        .nmi2_wr_i(nmi2_wr_i), .nmi2_wd_i(nmi2_wd_i),
        .rd1_i(rd1_i), .rd2_i(rd2_i),
        .stat1_o(stat1_o), .stat2_o(stat2_o),
        .smi_o(smi_o), .irq_o(irq_o), .nmi_o(nmi_o)
    );

    function automatic int sx(input logic [7:0] b);
        return (b > 8'd127) ? int'(b) - 256 : int'(b);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    // one clock: compute the model's next state, advance, compare
    task automatic step();
        int set1 = 0, set2 = 0, nh = m_hot, nc = m_chas, n1 = 0, n2 = 0;
        int ts, th, ty, ms, mn;
        bit e_smi, e_irq, e_nmi;
        if (rst_n) begin
            if (upd_i) begin
                for (int i = 0; i < NV; i++) begin
                    bit viol = ((vhi[i] != 255) && (volt[i] > vhi[i])) || (volt[i] < vlo[i]);
                    if (viol) begin
                        if (i < 4) set1 |= (1 << i);
                        else       set2 |= (1 << (i - 4));
                    end
                end
                ts = sx(temp_i); th = sx(temp_hi_i); ty = sx(temp_hyst_i);
                if (temp_hyst_i == 8'd127) begin
                    if (ts > th) set1 |= 16;
                    nh = (ts > th) ? 1 : 0;
                end else if (m_hot == 0 && ts > th) begin
                    set1 |= 16; nh = 1;
                end else if (m_hot == 1 && ts < ty) begin
                    set1 |= 16; nh = 0;
                end
                if (flim[0] != 255 && fan[0] > flim[0]) set1 |= 64;
                if (flim[1] != 255 && fan[1] > flim[1]) set1 |= 128;
                if (flim[2] != 255 && fan[2] > flim[2]) set2 |= 8;
            end
            if (bti_ev_i)  set1 |= 32;
            if (ovf_ev_i)  set2 |= 32;
            if (smi_ev_i)  set2 |= 64;
            if (m_chas != 0) set2 |= 16;
            n1 = rd1_i ? set1 : (m_s1 | set1);
            n2 = rd2_i ? set2 : (m_s2 | set2);
            if (chas_ev_i) nc = 1;
            else if (nmi2_wr_i && nmi2_wd_i[7]) nc = 0;
        end else begin
            nh = 0; nc = 0;
        end
        @(posedge clk);
        @(negedge clk);
        m_s1 = n1; m_s2 = n2; m_hot = nh; m_chas = nc;
        ms = (m_s1 & int'(smi_mask_i[7:0])) | (m_s2 & int'(smi_mask_i[15:8]));
        mn = (m_s1 & int'(nmi_mask_i[7:0])) | (m_s2 & int'(nmi_mask_i[15:8]));
        e_smi = (ms != 0) && cfg_i[1] && !cfg_i[3];
        e_nmi = (mn != 0) && cfg_i[2] && !cfg_i[3] && cfg_i[5];
        e_irq = (mn != 0) && cfg_i[2] && !cfg_i[3] && !cfg_i[5];
        nvec++;
        if (stat1_o !== m_s1[7:0] || stat2_o !== m_s2[7:0] ||
            smi_o !== e_smi || irq_o !== e_irq || nmi_o !== e_nmi) begin
            nbad++;
            $display("FAIL %s: stat1=%02h stat2=%02h smi/irq/nmi=%b%b%b expected stat1=%02h stat2=%02h smi/irq/nmi=%b%b%b",
                     cur_req, stat1_o, stat2_o, smi_o, irq_o, nmi_o,
                     m_s1[7:0], m_s2[7:0], e_smi, e_irq, e_nmi);
        end
    endtask

    task automatic upd_step();
        upd_i = 1'b1; step(); upd_i = 1'b0;
    endtask

    task automatic read_both();
        rd1_i = 1'b1; rd2_i = 1'b1; step(); rd1_i = 1'b0; rd2_i = 1'b0; step();
    endtask

    initial begin
        #(200000 * 10);
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        nvec = 0; nbad = 0; done = 1'b0;
        m_s1 = 0; m_s2 = 0; m_hot = 0; m_chas = 0;
        rst_n = 1'b0; upd_i = 1'b0; bti_ev_i = 1'b0; ovf_ev_i = 1'b0;
        smi_ev_i = 1'b0; chas_ev_i = 1'b0; nmi2_wr_i = 1'b0; nmi2_wd_i = 8'h00;
        rd1_i = 1'b0; rd2_i = 1'b0; cfg_i = 8'h00;
        smi_mask_i = 16'h0000; nmi_mask_i = 16'h0000;
        for (int i = 0; i < NV; i++) begin volt[i] = 8'h80; vhi[i] = 8'hC0; vlo[i] = 8'h40; end
        for (int i = 0; i < NF; i++) begin fan[i] = 8'h50; flim[i] = 8'h80; end
        temp_i = 8'd25; temp_hi_i = 8'd60; temp_hyst_i = 8'd50;
        @(negedge clk);

        cur_req = "R13";   // reset clears everything
        bti_ev_i = 1'b1; chas_ev_i = 1'b1;
        repeat (3) step();
        bti_ev_i = 1'b0; chas_ev_i = 1'b0;
        rst_n = 1'b1;
        step();

        cur_req = "R1";    // window violations and exact-limit boundaries
        upd_step();
        volt[0] = 8'hD0; volt[4] = 8'h20; volt[3] = 8'hC0; volt[6] = 8'h40;
        upd_step(); step();
        volt[1] = 8'h3F; volt[5] = 8'hC1;
        upd_step();
        read_both();
        for (int i = 0; i < NV; i++) volt[i] = 8'h80;

        cur_req = "R2";    // all-ones high limit turns off the high side only
        vhi[2] = 8'hFF; volt[2] = 8'hFF;
        upd_step(); step();
        volt[2] = 8'h10;
        upd_step();
        read_both();
        volt[2] = 8'h80; vhi[2] = 8'hC0;

        cur_req = "R3";    // hysteresis mode
        foreach (volt[i]) volt[i] = 8'h80;
        temp_i = 8'd70; upd_step(); read_both();
        temp_i = 8'd65; upd_step();
        temp_i = 8'd55; upd_step();
        temp_i = 8'd45; upd_step(); read_both();
        temp_i = 8'd45; upd_step();
        temp_i = 8'd70; upd_step(); read_both();
        temp_i = 8'd30; upd_step(); read_both();

        cur_req = "R5";    // signed compares
        temp_hi_i = 8'hF6; temp_hyst_i = 8'hEC;
        temp_i = 8'hFE; upd_step(); read_both();
        temp_i = 8'h05; upd_step();
        temp_i = 8'h80; upd_step(); read_both();
        temp_i = 8'hF0; upd_step(); read_both();

        cur_req = "R4";    // comparator mode
        temp_hi_i = 8'd60; temp_hyst_i = 8'd127;
        temp_i = 8'd70; upd_step(); read_both();
        upd_step(); read_both();
        temp_i = 8'd60; upd_step(); read_both();
        temp_i = 8'd25; temp_hyst_i = 8'd50; upd_step();

        cur_req = "R6";    // fan limits
        fan[1] = 8'h90; fan[0] = 8'h80; flim[2] = 8'hFF; fan[2] = 8'hFF;
        upd_step(); step(); read_both();
        flim[2] = 8'h20; upd_step(); read_both();
        foreach (fan[i]) fan[i] = 8'h50;
        flim[2] = 8'h80;

        cur_req = "R7";    // external event inputs
        bti_ev_i = 1'b1; step(); bti_ev_i = 1'b0;
        ovf_ev_i = 1'b1; step(); ovf_ev_i = 1'b0;
        smi_ev_i = 1'b1; step(); smi_ev_i = 1'b0;
        step(); read_both();

        cur_req = "R8";    // read clears, same-cycle set survives
        bti_ev_i = 1'b1; step();
        rd1_i = 1'b1; step(); bti_ev_i = 1'b0; step(); rd1_i = 1'b0; step();

        cur_req = "R9";    // no update, no comparison
        volt[0] = 8'hF0; fan[0] = 8'hF0; temp_i = 8'd90;
        repeat (3) step();
        upd_step(); step();
        volt[0] = 8'h80; fan[0] = 8'h50; temp_i = 8'd25;
        upd_step(); read_both();

        cur_req = "R10";   // masking, enables, route
        bti_ev_i = 1'b1; step(); bti_ev_i = 1'b0;
        smi_mask_i = 16'h0020; cfg_i = 8'h02; step();
        smi_mask_i = 16'h0010; step();
        nmi_mask_i = 16'h0020; cfg_i = 8'h04; step();
        cfg_i = 8'h24; step();
        cfg_i = 8'h20; step();
        ovf_ev_i = 1'b1; step(); ovf_ev_i = 1'b0;
        nmi_mask_i = 16'h2000; cfg_i = 8'h26; smi_mask_i = 16'h2000; step();

        cur_req = "R11";   // quiet override
        cfg_i = 8'h2E; step(); step();
        cfg_i = 8'h06; step();
        read_both();

        cur_req = "R12";   // chassis latch
        nmi_mask_i = 16'h1000;
        chas_ev_i = 1'b1; step(); chas_ev_i = 1'b0;
        step(); step();
        read_both(); read_both();
        nmi2_wr_i = 1'b1; nmi2_wd_i = 8'h7F; step(); nmi2_wr_i = 1'b0;
        read_both();
        nmi2_wr_i = 1'b1; nmi2_wd_i = 8'h80; chas_ev_i = 1'b1; step();
        chas_ev_i = 1'b0; step(); nmi2_wr_i = 1'b0;
        step(); read_both(); read_both();
        cfg_i = 8'h00; nmi_mask_i = 16'h0000;

        cur_req = "R8";    // random mix over every path
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < NV; i++) begin
                volt[i] = int'($urandom_range(255));
                if ($urandom_range(15) == 0) vhi[i] = ($urandom_range(3) == 0) ? 255 : int'($urandom_range(255));
                if ($urandom_range(15) == 0) vlo[i] = int'($urandom_range(128));
            end
            for (int i = 0; i < NF; i++) begin
                fan[i] = int'($urandom_range(255));
                if ($urandom_range(15) == 0) flim[i] = ($urandom_range(3) == 0) ? 255 : int'($urandom_range(255));
            end
            temp_i = 8'($urandom_range(255));
            if ($urandom_range(31) == 0) temp_hi_i = 8'($urandom_range(255));
            if ($urandom_range(31) == 0) temp_hyst_i = ($urandom_range(2) == 0) ? 8'd127 : 8'($urandom_range(255));
            upd_i     = ($urandom_range(3) == 0);
            bti_ev_i  = ($urandom_range(15) == 0);
            ovf_ev_i  = ($urandom_range(15) == 0);
            smi_ev_i  = ($urandom_range(15) == 0);
            chas_ev_i = ($urandom_range(63) == 0);
            nmi2_wr_i = ($urandom_range(15) == 0);
            nmi2_wd_i = 8'($urandom_range(255));
            rd1_i     = ($urandom_range(3) == 0);
            rd2_i     = ($urandom_range(3) == 0);
            if ($urandom_range(15) == 0) cfg_i = 8'($urandom_range(255));
            if ($urandom_range(15) == 0) smi_mask_i = 16'($urandom_range(65535));
            if ($urandom_range(15) == 0) nmi_mask_i = 16'($urandom_range(65535));
            step();
        end
        upd_i = 1'b0; bti_ev_i = 1'b0; ovf_ev_i = 1'b0; smi_ev_i = 1'b0;
        chas_ev_i = 1'b0; nmi2_wr_i = 1'b0; rd1_i = 1'b0; rd2_i = 1'b0;
        step();
        finish_run();
    end
endmodule